// File: doc/BRIEF.md
# Frame Completion Status Encoder

This block sits at the tail of a network controller's frame engine. When a frame finishes in either direction, the engine pulses a single strobe. With it come the controller's status word, the direction, the number of 16-bit words moved, a hardware count of surplus bytes and two buffer flags. One clock later the block presents three things: a 16-bit completion word for the host descriptor, a byte length, and exactly one disposition. The disposition is post (write the completion), retry (transmit collision early in the frame) or drop (receive runt).

On receive, the byte length is the word count doubled, less the surplus-byte count. A result below five bytes is discarded silently. Any other result is reported with three added, together with the masked receive error bits merged into the good code. On transmit, a clean frame posts the good code. An error other than a plain collision posts the masked transmit error bits unchanged. A plain collision leads to a retry, unless the frame had already moved at least `LATE_WORDS` words; in that case it is reported as a late collision with the doubled word count.

Top module: `frame_cmpl_enc`

## Requirements
- R1: While reset is held and on the first cycle after release, `done`, `post`, `retry` and `drop` are 0, and `completion` and `byte_len` are 0.
- R2: `done` is high in exactly the cycle after each cycle in which `frame_end` is high, and low otherwise.
- R3: Receive (`is_tx`=0), no flags, computed length L = 2·`xfer_words` − `excess_bytes` ≥ 5: `post`=1, `completion` = (`ctl_status` AND 16'h0F00) OR 16'h4000, `byte_len` = L + 3.
- R4: Receive, no flags, L < 5 (including negative L): `drop`=1 and `post`=0.
- R5: Receive with `buf_overrun`=1 and `zero_len`=0: `post`=1, `completion`=16'h6200, `byte_len` = 2·`xfer_words`, with no runt test.
- R6: `zero_len`=1 in either direction overrides every other input: `post`=1, `completion`=16'h6800, `byte_len`=0.
- R7: Transmit (`is_tx`=1) with (`ctl_status` AND 16'h00F0) = 0: `post`=1, `completion`=16'h4000, `byte_len` = 2·`xfer_words`.
- R8: Transmit where the masked transmit bits equal exactly 16'h0020 (collision) and `xfer_words` < `LATE_WORDS` (default 168): `retry`=1, `post`=0.
- R9: Transmit, collision only, `xfer_words` ≥ `LATE_WORDS`: `post`=1, `completion`=16'h6600, `byte_len` = 2·`xfer_words`.
- R10: Transmit where the masked transmit bits are nonzero and not exactly the collision bit: `post`=1, `completion` = `ctl_status` AND 16'h00F0, `byte_len` = 2·`xfer_words`.
- R11: On a `done` cycle exactly one of `post`, `retry`, `drop` is high; on any other cycle all three are low.
- R12: Status bits outside the direction's mask (receive mask 16'h0F00, transmit mask 16'h00F0) have no effect. On transmit, `excess_bytes` and `buf_overrun` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_end | input | 1 | One-cycle strobe: frame finished, inputs valid |
| is_tx | input | 1 | 1 = transmit frame, 0 = receive frame |
| ctl_status | input | 16 | Controller status word |
| xfer_words | input | WORD_W | 16-bit words moved in the frame |
| excess_bytes | input | EXC_W | Surplus byte count reported by the receiver |
| buf_overrun | input | 1 | Receive buffer filled before end of frame |
| zero_len | input | 1 | Host buffer empty or too small |
| done | output | 1 | Result valid this cycle |
| post | output | 1 | Write completion word and length |
| retry | output | 1 | Transmit must be reattempted |
| drop | output | 1 | Receive frame silently discarded |
| completion | output | 16 | Completion word |
| byte_len | output | WORD_W+2 | Byte length to record |

## Verification
The bound checker watches timing and exclusivity on every cycle. It checks the one-cycle strobe-to-done latency and that exactly one disposition is chosen per frame. It also checks that retries only follow transmit collisions and drops only follow receives, that a late-collision code implies a word count at or above the threshold, and that a good receive word carries no transmit bits. The exact arithmetic cannot be shown by these properties: the length subtraction and the plus-three offset, the runt edge at four and five bytes, the 167/168 collision boundary, flag priority and the indifference to foreign status bits. Those are shown only by the bench's directed corners and its seeded random frames, compared against its own model.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
   localparam logic [15:0] RX_ERR_MASK    = 16'h0F00;
   localparam logic [15:0] TX_ERR_MASK    = 16'h00F0;
   localparam logic [15:0] TX_COLL_ONLY   = 16'h0020;
   localparam logic [15:0] CODE_GOOD      = 16'h4000;
   localparam logic [15:0] CODE_SHORT_BUF = 16'h6800;
   localparam logic [15:0] CODE_RX_OVF    = 16'h6200;
   localparam logic [15:0] CODE_LATE_COLL = 16'h6600;
   localparam int          RUNT_BYTES     = 5;
   localparam int          LEN_PAD        = 3;

   typedef enum logic [1:0] {
      DISP_POST  = 2'd0,
      DISP_RETRY = 2'd1,
      DISP_DROP  = 2'd2
   } disp_e;
endpackage

// File: rtl/fcs_rx_eval.sv
module fcs_rx_eval
   import fcs_pkg::*;
#(
   parameter int WORD_W = 12,
   parameter int EXC_W  = 5,
   localparam int LEN_W = WORD_W + 2
) (
   input  logic [15:0]       status,
   input  logic [WORD_W-1:0] words,
   input  logic [EXC_W-1:0]  excess,
   input  logic              overrun,
   input  logic              zero_len,
   output disp_e             disp,
   output logic [15:0]       comp,
   output logic [LEN_W-1:0]  len
);
   localparam int SW = LEN_W + 1;

   logic [SW-1:0] twice;
   logic [SW-1:0] diff;
   logic          runt;

   always_comb begin
      twice = SW'(words) << 1;
      diff  = twice - SW'(excess);
      runt  = diff[SW-1] || (diff < SW'(RUNT_BYTES));
   end

   always_comb begin
      disp = DISP_POST;
      comp = CODE_GOOD;
      len  = '0;
      if (zero_len) begin
         comp = CODE_SHORT_BUF;
      end else if (overrun) begin
         comp = CODE_RX_OVF;
         len  = twice[LEN_W-1:0];
      end else if (runt) begin
         disp = DISP_DROP;
         comp = '0;
      end else begin
         comp = (status & RX_ERR_MASK) | CODE_GOOD;
         len  = diff[LEN_W-1:0] + LEN_W'(LEN_PAD);
      end
   end
endmodule

// File: rtl/fcs_tx_eval.sv
module fcs_tx_eval
   import fcs_pkg::*;
#(
   parameter int WORD_W     = 12,
   parameter int LATE_WORDS = 168,
   localparam int LEN_W     = WORD_W + 2
) (
   input  logic [15:0]       status,
   input  logic [WORD_W-1:0] words,
   input  logic              zero_len,
   output disp_e             disp,
   output logic [15:0]       comp,
   output logic [LEN_W-1:0]  len
);
   logic [15:0] masked;
   logic        late;

   always_comb begin
      masked = status & TX_ERR_MASK;
      late   = words >= WORD_W'(LATE_WORDS);
   end

   always_comb begin
      disp = DISP_POST;
      comp = CODE_GOOD;
      len  = LEN_W'(words) << 1;
      if (zero_len) begin
         comp = CODE_SHORT_BUF;
         len  = '0;
      end else if (masked == '0) begin
         comp = CODE_GOOD;
      end else if (masked == TX_COLL_ONLY) begin
         if (late) begin
            comp = CODE_LATE_COLL;
         end else begin
            disp = DISP_RETRY;
            comp = '0;
            len  = '0;
         end
      end else begin
         comp = masked;
      end
   end
endmodule

// File: rtl/frame_cmpl_enc.sv
module frame_cmpl_enc
   import fcs_pkg::*;
#(
   parameter int WORD_W     = 12,
   parameter int EXC_W      = 5,
   parameter int LATE_WORDS = 168,
   localparam int LEN_W     = WORD_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_end,
   input  logic              is_tx,
   input  logic [15:0]       ctl_status,
   input  logic [WORD_W-1:0] xfer_words,
   input  logic [EXC_W-1:0]  excess_bytes,
   input  logic              buf_overrun,
   input  logic              zero_len,
   output logic              done,
   output logic              post,
   output logic              retry,
   output logic              drop,
   output logic [15:0]       completion,
   output logic [LEN_W-1:0]  byte_len
);
   generate
      if (WORD_W < 4 || WORD_W > 28) begin : g_bad_word_w
         $error("WORD_W out of range");
      end
      if (EXC_W < 1 || EXC_W > WORD_W) begin : g_bad_exc_w
         $error("EXC_W out of range");
      end
      if (LATE_WORDS < 1 || LATE_WORDS >= (1 << WORD_W)) begin : g_bad_late
         $error("LATE_WORDS must be reachable by xfer_words");
      end
   endgenerate

   disp_e            rx_disp, tx_disp, sel_disp;
   logic [15:0]      rx_comp, tx_comp, sel_comp;
   logic [LEN_W-1:0] rx_len, tx_len, sel_len;

   fcs_rx_eval #(.WORD_W(WORD_W), .EXC_W(EXC_W)) u_rx (
      .status   (ctl_status),
      .words    (xfer_words),
      .excess   (excess_bytes),
      .overrun  (buf_overrun),
      .zero_len (zero_len),
      .disp     (rx_disp),
      .comp     (rx_comp),
      .len      (rx_len)
   );

   fcs_tx_eval #(.WORD_W(WORD_W), .LATE_WORDS(LATE_WORDS)) u_tx (
      .status   (ctl_status),
      .words    (xfer_words),
      .zero_len (zero_len),
      .disp     (tx_disp),
      .comp     (tx_comp),
      .len      (tx_len)
   );

   always_comb begin
      sel_disp = is_tx ? tx_disp : rx_disp;
      sel_comp = is_tx ? tx_comp : rx_comp;
      sel_len  = is_tx ? tx_len  : rx_len;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done       <= 1'b0;
         post       <= 1'b0;
         retry      <= 1'b0;
         drop       <= 1'b0;
         completion <= '0;
         byte_len   <= '0;
      end else begin
         done  <= frame_end;
         post  <= frame_end && (sel_disp == DISP_POST);
         retry <= frame_end && (sel_disp == DISP_RETRY);
         drop  <= frame_end && (sel_disp == DISP_DROP);
         if (frame_end) begin
            completion <= sel_comp;
            byte_len   <= sel_len;
         end
      end
   end
endmodule

// File: rtl/fcs_chk.sv
module fcs_chk #(
   parameter int WORD_W     = 12,
   parameter int EXC_W      = 5,
   parameter int LATE_WORDS = 168,
   localparam int LEN_W     = WORD_W + 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_end,
   input logic              is_tx,
   input logic [15:0]       ctl_status,
   input logic [WORD_W-1:0] xfer_words,
   input logic [EXC_W-1:0]  excess_bytes,
   input logic              buf_overrun,
   input logic              zero_len,
   input logic              done,
   input logic              post,
   input logic              retry,
   input logic              drop,
   input logic [15:0]       completion,
   input logic [LEN_W-1:0]  byte_len
);
   a_r2_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> done);
   a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end |=> !done);
   a_r11_one_disposition: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $onehot({post, retry, drop}));
   a_r11_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> !(post || retry || drop));
   a_r8_retry_from_tx_collision: assert property (@(posedge clk) disable iff (!rst_n)
      retry |-> ($past(is_tx) && $past(ctl_status[5]) && $past(xfer_words) < WORD_W'(LATE_WORDS)));
   a_r4_drop_only_on_rx: assert property (@(posedge clk) disable iff (!rst_n)
      drop |-> !$past(is_tx));
   a_r9_late_needs_threshold: assert property (@(posedge clk) disable iff (!rst_n)
      (post && completion == 16'h6600) |-> $past(xfer_words) >= WORD_W'(LATE_WORDS));
   a_r3_rx_good_no_tx_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (post && !$past(is_tx) && completion[15:12] == 4'h4) |-> completion[7:0] == 8'h00);
   a_r6_short_buffer_len: assert property (@(posedge clk) disable iff (!rst_n)
      (post && $past(zero_len)) |-> (completion == 16'h6800 && byte_len == '0));
   a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_end && !$past(frame_end) && $past(rst_n)) |=> $stable(completion));
endmodule

bind frame_cmpl_enc fcs_chk #(
   .WORD_W(WORD_W), .EXC_W(EXC_W), .LATE_WORDS(LATE_WORDS)
) u_chk (.*);

// File: tb/frame_cmpl_enc_tb.sv
module frame_cmpl_enc_tb;
   localparam int WORD_W = 12;
   localparam int EXC_W  = 5;
   localparam int LATE   = 168;
   localparam int LEN_W  = WORD_W + 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              frame_end = 1'b0;
   logic              is_tx = 1'b0;
   logic [15:0]       ctl_status = '0;
   logic [WORD_W-1:0] xfer_words = '0;
   logic [EXC_W-1:0]  excess_bytes = '0;
   logic              buf_overrun = 1'b0;
   logic              zero_len = 1'b0;
   logic              done, post, retry, drop;
   logic [15:0]       completion;
   logic [LEN_W-1:0]  byte_len;

   int n_chk = 0;
   int n_bad = 0;

   bit          e_post, e_retry, e_drop;
   logic [15:0] e_comp;
   int          e_len;
   string       e_req;

   always #5 clk = ~clk;

   frame_cmpl_enc #(.WORD_W(WORD_W), .EXC_W(EXC_W), .LATE_WORDS(LATE)) u_dut (.*);

   task automatic check(string req, string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic void model(bit tx, logic [15:0] st, int w, int ex, bit ovf, bit zl);
      logic [15:0] m;
      int d;
      e_post = 0; e_retry = 0; e_drop = 0; e_comp = '0; e_len = 0;
      if (zl) begin
         e_req = "R6"; e_post = 1; e_comp = 16'h6800;
      end else if (!tx) begin
         if (ovf) begin
            e_req = "R5"; e_post = 1; e_comp = 16'h6200; e_len = 2 * w;
         end else begin
            d = 2 * w - ex;
            if (d < 5) begin
               e_req = "R4"; e_drop = 1;
            end else begin
               e_req = "R3"; e_post = 1; e_comp = (st & 16'h0F00) | 16'h4000; e_len = d + 3;
            end
         end
      end else begin
         m = st & 16'h00F0;
         if (m == 16'h0000) begin
            e_req = "R7"; e_post = 1; e_comp = 16'h4000; e_len = 2 * w;
         end else if (m == 16'h0020) begin
            if (w < LATE) begin
               e_req = "R8"; e_retry = 1;
            end else begin
               e_req = "R9"; e_post = 1; e_comp = 16'h6600; e_len = 2 * w;
            end
         end else begin
            e_req = "R10"; e_post = 1; e_comp = m; e_len = 2 * w;
         end
      end
   endfunction

   task automatic frame(bit tx, logic [15:0] st, int w, int ex, bit ovf, bit zl);
      @(negedge clk);
      check("R2", "done idle", done, 0);
      is_tx = tx; ctl_status = st; xfer_words = WORD_W'(w);
      excess_bytes = EXC_W'(ex); buf_overrun = ovf; zero_len = zl;
      frame_end = 1'b1;
      model(tx, st, w, ex, ovf, zl);
      @(negedge clk);
      frame_end = 1'b0;
      check("R2", "done", done, 1);
      check(e_req, "post", post, e_post);
      check(e_req, "retry", retry, e_retry);
      check(e_req, "drop", drop, e_drop);
      if (e_post) begin
         check(e_req, "completion", completion, e_comp);
         check(e_req, "byte_len", byte_len, e_len);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin : stim
      int w;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      // R1: reset values while held
      check("R1", "done", done, 0);
      check("R1", "flags", {post, retry, drop}, 0);
      check("R1", "completion", completion, 0);
      check("R1", "byte_len", byte_len, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "done after release", done, 0);

      // R3 / R4 runt edge: 3 words less 1 -> 5 bytes kept, less 2 -> dropped
      frame(0, 16'h0000, 3, 1, 0, 0);
      frame(0, 16'h0000, 3, 2, 0, 0);
      frame(0, 16'h0000, 0, 0, 0, 0);
      frame(0, 16'h0000, 1, 31, 0, 0);
      frame(0, 16'h0500, 30, 3, 0, 0);
      // R12: foreign status bits ignored on receive
      frame(0, 16'hF0FF, 40, 0, 0, 0);
      // R5: overrun beats runt
      frame(0, 16'h0F00, 1, 9, 1, 0);
      // R6: zero-length in both directions
      frame(0, 16'hFFFF, 50, 4, 1, 1);
      frame(1, 16'h0020, 300, 0, 0, 1);
      // R7 with R12: excess/overrun/foreign bits ignored on transmit
      frame(1, 16'hFF0F, 64, 31, 1, 0);
      // R8 / R9 boundary at LATE_WORDS
      frame(1, 16'h0020, LATE - 1, 0, 0, 0);
      frame(1, 16'h0020, LATE, 0, 0, 0);
      frame(1, 16'h8F2F, 0, 0, 0, 0);
      // R10: mixed transmit errors
      frame(1, 16'h0060, 200, 0, 0, 0);
      frame(1, 16'h0010, 10, 0, 0, 0);

      for (int i = 0; i < 400; i++) begin
         case ($urandom_range(0, 3))
            0: w = $urandom_range(0, 6);
            1: w = $urandom_range(LATE - 3, LATE + 3);
            default: w = $urandom_range(0, (1 << WORD_W) - 1);
         endcase
         frame($urandom_range(0, 1), 16'($urandom()), w, $urandom_range(0, 31),
               ($urandom_range(0, 7) == 0), ($urandom_range(0, 15) == 0));
      end
      @(negedge clk);
      check("R11", "flags idle", {post, retry, drop}, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule